// File: doc/BRIEF.md
# Rational Resize Phase Sequencer

This block turns a reduced resize ratio `num:denom` into the per-phase schedule that a polyphase resampler walks through. After a start strobe it produces exactly `num` entries, one per output phase. Each entry carries a blend weight on a 0..512 scale (512 means the whole of the current source pixel), the number of source pixels to step over after that phase, the phase index, and a flag that forces nearest-neighbour filtering.

The ratio picks one of three stepping schemes. When the denominator is larger than the numerator the image shrinks, and a modular accumulator seeded with the denominator spreads the advances across the phases. A denominator of one is a whole-number enlargement: every phase takes the full weight with nearest-neighbour forced, and only the final phase steps the source. Every other ratio is a fractional enlargement driven by an accumulator that starts at zero. The divisions are done by a small shared iterative divider. Entries leave on a valid/ready stream and a downstream stall freezes the sequencer. A one-cycle done pulse marks the end of a run.

Top module: `rsz_phase_seq`

## Requirements
- R1: A start with num equal to 0, num above 31, or denom equal to 0 is rejected. err_o pulses high in the following cycle, the block stays idle and no entry is produced.
- R2: The mode is shrink when denom > num, whole enlargement when denom == 1 (and not shrink), and fractional enlargement otherwise. ent_nearest_o is 1 exactly in whole-enlargement entries.
- R3: Fractional enlargement: acc starts at 0. Each phase emits weight = 512 - floor(512*acc/num). Then acc += denom. If acc >= num, the phase emits advance 1 and acc -= num; otherwise it emits advance 0.
- R4: Whole enlargement: every entry has weight 512 and ent_nearest_o = 1. The advance is 1 on phase num-1 and 0 on every other phase.
- R5: Shrink: acc starts at denom. Each phase sets acc = num + ((acc - num) mod 2num) and emits weight = 512 - floor(512*(acc-num)/(2num)). It then adds 2*denom to acc and emits advance = floor((acc-num)/(2num)).
- R6: A run delivers exactly num entries with ent_phase_o running 0, 1, ..., num-1.
- R7: While ent_valid_o is high and ent_ready_i is low, the next cycle still has ent_valid_o high with weight, advance, phase and nearest flag unchanged.
- R8: A start while busy_o is high is ignored. The run in progress completes unchanged and no second run follows it.
- R9: done_o is high for exactly one cycle, the cycle after the handshake of the last entry, and is low at all other times.
- R10: Every entry's weight lies in 1..512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| num_i | input | NUM_W (6) | Reduced ratio numerator (output phases) |
| den_i | input | DEN_W (8) | Reduced ratio denominator |
| busy_o | output | 1 | A run is in progress |
| err_o | output | 1 | One-cycle pulse: the start was rejected |
| ent_valid_o | output | 1 | Entry valid |
| ent_ready_i | input | 1 | Entry accepted downstream |
| ent_weight_o | output | 10 | Blend weight, 0..512 scale |
| ent_adv_o | output | ACC_W (10) | Source pixels to advance after this phase |
| ent_phase_o | output | PH_W (5) | Phase index |
| ent_nearest_o | output | 1 | Force nearest-neighbour for this phase |
| done_o | output | 1 | One-cycle pulse after the last entry |

## Verification
The bench uses the default parameters: at most 31 phases, a 6-bit numerator port and an 8-bit denominator. The 6-bit numerator lets the bench offer numerators of 32 to 63 and so exercise the rejection path. The 8-bit denominator reaches shrink ratios as steep as 1:255, where a single phase advances the source by 255, so the accumulator and the divider run near their widest values. Table lengths from 1 up to the full 31 phases are covered by directed cases and by seeded random reduced ratios under random backpressure.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

  typedef enum logic [1:0] {
    MODE_SHRINK  = 2'd0,
    MODE_WHOLEUP = 2'd1,
    MODE_FRACUP  = 2'd2
  } rsz_mode_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PREP = 3'd1,
    S_GO   = 3'd2,
    S_WAIT = 3'd3,
    S_EMIT = 3'd4
  } rsz_state_e;

  typedef enum logic [1:0] {
    OP_MOD = 2'd0,
    OP_WGT = 2'd1,
    OP_ADV = 2'd2
  } rsz_op_e;

  // Ratio to stepping scheme; the shrink test takes priority.
  function automatic rsz_mode_e pick_mode(input logic [31:0] n, input logic [31:0] d);
    if (d > n)       return MODE_SHRINK;
    else if (d == 1) return MODE_WHOLEUP;
    else             return MODE_FRACUP;
  endfunction

  // Weight from the quotient of the scaled fraction.
  function automatic logic [9:0] weight_of(input logic [9:0] q);
    return 10'd512 - q;
  endfunction

endpackage

// File: rtl/rsz_div.sv
module rsz_div #(
  parameter int N_W = 19,
  parameter int D_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic [N_W-1:0] dvd_i,
  input  logic [D_W-1:0] dvs_i,
  output logic           done_o,
  output logic [N_W-1:0] quo_o,
  output logic [D_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [N_W-1:0]   q;
  logic [D_W-1:0]   r;
  logic [D_W-1:0]   dvs_r;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             done_r;
  logic [D_W:0]     trial;
  logic             take;

  assign trial = {r, q[N_W-1]};
  assign take  = trial >= {1'b0, dvs_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q      <= '0;
      r      <= '0;
      dvs_r  <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (go_i) begin
        q     <= dvd_i;
        r     <= '0;
        dvs_r <= dvs_i;
        cnt   <= CNT_W'(N_W);
        run   <= 1'b1;
      end else if (run) begin
        if (take) r <= D_W'(trial - {1'b0, dvs_r});
        else      r <= trial[D_W-1:0];
        q   <= {q[N_W-2:0], take};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run    <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_r;
  assign quo_o  = q;
  assign rem_o  = r;

  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rem_o < dvs_r)); // R5

endmodule

// File: rtl/rsz_mode_dec.sv
module rsz_mode_dec
  import rsz_pkg::*;
#(
  parameter int NUM_W  = 6,
  parameter int DEN_W  = 8,
  parameter int MAX_PH = 31
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output rsz_mode_e        mode_o,
  output logic             reject_o
);
  assign mode_o   = pick_mode(32'(num_i), 32'(den_i));
  assign reject_o = (num_i == '0) || (32'(num_i) > MAX_PH) || (den_i == '0);
endmodule

// File: rtl/rsz_phase_seq.sv
module rsz_phase_seq
  import rsz_pkg::*;
#(
  parameter int MAX_PH = 31,
  parameter int NUM_W  = 6,
  parameter int DEN_W  = 8,
  localparam int PH_W  = $clog2(MAX_PH + 1),
  localparam int ACC_W = ((DEN_W > PH_W + 2) ? DEN_W : PH_W + 2) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             err_o,
  output logic             ent_valid_o,
  input  logic             ent_ready_i,
  output logic [9:0]       ent_weight_o,
  output logic [ACC_W-1:0] ent_adv_o,
  output logic [PH_W-1:0]  ent_phase_o,
  output logic             ent_nearest_o,
  output logic             done_o
);
  localparam int WGT_W = 10;
  localparam int WSH   = 9;
  localparam int DVS_W = PH_W + 1;
  localparam int DVD_W = ACC_W + WSH;
  localparam logic [WGT_W-1:0] FULL = WGT_W'(512);

  rsz_state_e       st;
  rsz_op_e          op;
  rsz_mode_e        mode_r;
  rsz_mode_e        mode_in;
  logic             reject_in;
  logic [PH_W-1:0]  num_r;
  logic [DEN_W-1:0] den_r;
  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  phase;
  logic [WGT_W-1:0] wgt_r;
  logic [ACC_W-1:0] adv_r;
  logic             nn_r;
  logic             done_r;
  logic             err_r;

  // Named internal events for the checks.
  logic             ent_fire;
  logic             last_phase;
  logic             last_fire;
  logic             div_go;
  logic             div_done;
  logic [DVD_W-1:0] div_dvd;
  logic [DVS_W-1:0] div_dvs;
  logic [DVD_W-1:0] div_q;
  logic [DVS_W-1:0] div_r;
  logic [ACC_W-1:0] acc_less_n;
  logic [ACC_W-1:0] frac_sum;
  logic [ACC_W-1:0] div_base;
  logic [DVS_W-1:0] two_n;

  rsz_mode_dec #(.NUM_W(NUM_W), .DEN_W(DEN_W), .MAX_PH(MAX_PH)) u_dec (
    .num_i(num_i), .den_i(den_i), .mode_o(mode_in), .reject_o(reject_in)
  );

  assign two_n      = {num_r, 1'b0};
  assign acc_less_n = acc - ACC_W'(num_r);
  assign frac_sum   = acc + ACC_W'(den_r);
  assign div_base   = (op == OP_WGT && mode_r == MODE_FRACUP) ? acc : acc_less_n;
  assign div_dvd    = (op == OP_WGT) ? {div_base, {WSH{1'b0}}} : {{WSH{1'b0}}, div_base};
  assign div_dvs    = (op == OP_WGT && mode_r == MODE_FRACUP) ? DVS_W'(num_r) : two_n;
  assign div_go     = (st == S_GO);

  rsz_div #(.N_W(DVD_W), .D_W(DVS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go_i(div_go), .dvd_i(div_dvd), .dvs_i(div_dvs),
    .done_o(div_done), .quo_o(div_q), .rem_o(div_r)
  );

  assign last_phase = (phase == num_r - PH_W'(1));
  assign ent_fire   = ent_valid_o && ent_ready_i;
  assign last_fire  = ent_fire && last_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op     <= OP_MOD;
      mode_r <= MODE_FRACUP;
      num_r  <= '0;
      den_r  <= '0;
      acc    <= '0;
      phase  <= '0;
      wgt_r  <= '0;
      adv_r  <= '0;
      nn_r   <= 1'b0;
      done_r <= 1'b0;
      err_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          if (reject_in) begin
            err_r <= 1'b1;
          end else begin
            mode_r <= mode_in;
            num_r  <= num_i[PH_W-1:0];
            den_r  <= den_i;
            phase  <= '0;
            acc    <= (mode_in == MODE_SHRINK) ? ACC_W'(den_i) : '0;
            st     <= S_PREP;
          end
        end
        S_PREP: begin
          if (mode_r == MODE_WHOLEUP) begin
            wgt_r <= FULL;
            nn_r  <= 1'b1;
            adv_r <= ACC_W'(last_phase);
            st    <= S_EMIT;
          end else begin
            nn_r <= 1'b0;
            op   <= (mode_r == MODE_SHRINK) ? OP_MOD : OP_WGT;
            st   <= S_GO;
          end
        end
        S_GO: st <= S_WAIT;
        S_WAIT: if (div_done) begin
          case (op)
            OP_MOD: begin
              acc <= ACC_W'(num_r) + ACC_W'(div_r);
              op  <= OP_WGT;
              st  <= S_GO;
            end
            OP_WGT: begin
              wgt_r <= weight_of(div_q[WGT_W-1:0]);
              if (mode_r == MODE_SHRINK) begin
                acc <= acc + ACC_W'({den_r, 1'b0});
                op  <= OP_ADV;
                st  <= S_GO;
              end else begin
                if (frac_sum >= ACC_W'(num_r)) begin
                  adv_r <= ACC_W'(1);
                  acc   <= frac_sum - ACC_W'(num_r);
                end else begin
                  adv_r <= '0;
                  acc   <= frac_sum;
                end
                st <= S_EMIT;
              end
            end
            default: begin
              adv_r <= div_q[ACC_W-1:0];
              st    <= S_EMIT;
            end
          endcase
        end
        S_EMIT: if (ent_ready_i) begin
          if (last_phase) begin
            done_r <= 1'b1;
            st     <= S_IDLE;
          end else begin
            phase <= phase + PH_W'(1);
            st    <= S_PREP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o        = (st != S_IDLE);
  assign err_o         = err_r;
  assign done_o        = done_r;
  assign ent_valid_o   = (st == S_EMIT);
  assign ent_weight_o  = wgt_r;
  assign ent_adv_o     = adv_r;
  assign ent_phase_o   = phase;
  assign ent_nearest_o = nn_r;

  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && reject_in) |=> (err_o && !busy_o)); // R1
  AST_FRAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid_o && mode_r == MODE_FRACUP) |-> (ent_adv_o <= ACC_W'(1) && !ent_nearest_o)); // R3
  AST_WHOLE_NEAREST: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid_o && mode_r == MODE_WHOLEUP) |-> (ent_nearest_o && ent_weight_o == FULL)); // R4
  AST_WGT_Q_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done && op == OP_WGT) |-> (div_q[DVD_W-1:WGT_W] == '0)); // R5
  AST_ADV_Q_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done && op == OP_ADV) |-> (div_q[DVD_W-1:ACC_W] == '0)); // R5
  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid_o |-> (ent_phase_o < num_r)); // R6
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid_o && !ent_ready_i) |=> (ent_valid_o && $stable(ent_weight_o) &&
      $stable(ent_adv_o) && $stable(ent_phase_o) && $stable(ent_nearest_o))); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(num_r) && $stable(den_r) && $stable(mode_r))); // R8
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(last_fire)); // R9
  AST_WGT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid_o |-> (ent_weight_o >= WGT_W'(1) && ent_weight_o <= FULL)); // R10

endmodule

// File: tb/rsz_phase_seq_tb_top.sv
`timescale 1ns/1ps
module rsz_phase_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [5:0] num_i = '0;
  logic [7:0] den_i = '0;
  logic       busy_o, err_o, ent_valid_o, ent_nearest_o, done_o;
  logic       ent_ready_i = 1'b0;
  logic [9:0] ent_weight_o;
  logic [9:0] ent_adv_o;
  logic [4:0] ent_phase_o;

  int checks = 0;
  int errors = 0;
  int ew [32];
  int ea [32];
  bit en [32];

  always #10 clk = ~clk;

  rsz_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .num_i(num_i), .den_i(den_i),
    .busy_o(busy_o), .err_o(err_o), .ent_valid_o(ent_valid_o), .ent_ready_i(ent_ready_i),
    .ent_weight_o(ent_weight_o), .ent_adv_o(ent_adv_o), .ent_phase_o(ent_phase_o),
    .ent_nearest_o(ent_nearest_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gcd(input int a, input int b);
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  // Expected schedule, restated from the requirements.
  task automatic build_expect(input int n, input int d);
    int a;
    if (d > n) begin
      a = d;
      for (int i = 0; i < n; i++) begin
        a = n + ((a - n) % (2 * n));
        ew[i] = 512 - (512 * (a - n)) / (2 * n);
        a = a + 2 * d;
        ea[i] = (a - n) / (2 * n);
        en[i] = 1'b0;
      end
    end else if (d == 1) begin
      for (int i = 0; i < n; i++) begin
        ew[i] = 512;
        ea[i] = (i == n - 1) ? 1 : 0;
        en[i] = 1'b1;
      end
    end else begin
      a = 0;
      for (int i = 0; i < n; i++) begin
        ew[i] = 512 - (512 * a) / n;
        a = a + d;
        if (a >= n) begin
          ea[i] = 1;
          a = a - n;
        end else begin
          ea[i] = 0;
        end
        en[i] = 1'b0;
      end
    end
  endtask

  task automatic run_case(input int n, input int d, input int ready_pct, input bit poke);
    int idx = 0;
    int guard = 0;
    bit held = 0;
    bit poked = 0;
    int hw = 0, ha = 0, hp = 0, hn = 0;
    string mreq;
    mreq = (d > n) ? "R5" : ((d == 1) ? "R4" : "R3");
    build_expect(n, d);
    start_i = 1'b1;
    num_i = 6'(n);
    den_i = 8'(d);
    @(negedge clk);
    start_i = 1'b0;
    while (idx < n && guard < 20000) begin
      guard++;
      start_i = 1'b0;
      ent_ready_i = (($urandom % 100) < ready_pct);
      if (held) begin
        check(ent_valid_o == 1'b1, "R7", "valid held under stall", int'(ent_valid_o), 1);
        check(int'(ent_weight_o) == hw && int'(ent_adv_o) == ha &&
              int'(ent_phase_o) == hp && int'(ent_nearest_o) == hn,
              "R7", "payload stable under stall", int'(ent_weight_o), hw);
      end
      check(done_o == 1'b0, "R9", "done low mid-run", int'(done_o), 0);
      if (ent_valid_o) begin
        if (poke && !poked && idx == 1) begin
          start_i = 1'b1;
          num_i = 6'd7;
          den_i = 8'd3;
          poked = 1;
        end
        if (ent_ready_i) begin
          check(int'(ent_phase_o) == idx, "R6", "phase index", int'(ent_phase_o), idx);
          check(int'(ent_weight_o) == ew[idx], mreq, "weight", int'(ent_weight_o), ew[idx]);
          check(int'(ent_adv_o) == ea[idx], mreq, "advance", int'(ent_adv_o), ea[idx]);
          check(ent_nearest_o == en[idx], "R2", "nearest flag / mode", int'(ent_nearest_o), int'(en[idx]));
          check(ent_weight_o >= 10'd1 && ent_weight_o <= 10'd512, "R10", "weight range", int'(ent_weight_o), 512);
          idx++;
        end
      end
      held = ent_valid_o && !ent_ready_i;
      hw = int'(ent_weight_o);
      ha = int'(ent_adv_o);
      hp = int'(ent_phase_o);
      hn = int'(ent_nearest_o);
      @(negedge clk);
    end
    start_i = 1'b0;
    ent_ready_i = 1'b0;
    check(idx == n, "R6", "entry count", idx, n);
    check(done_o == 1'b1, "R9", "done after last entry", int'(done_o), 1);
    @(negedge clk);
    check(done_o == 1'b0, "R9", "done one cycle wide", int'(done_o), 0);
    check(busy_o == 1'b0, "R6", "idle after run", int'(busy_o), 0);
    if (poke) begin
      for (int k = 0; k < 6; k++) begin
        check(ent_valid_o == 1'b0 && busy_o == 1'b0, "R8", "no run from ignored start",
              int'(ent_valid_o), 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic reject_case(input int n, input int d);
    start_i = 1'b1;
    num_i = 6'(n);
    den_i = 8'(d);
    @(negedge clk);
    start_i = 1'b0;
    check(err_o == 1'b1, "R1", "reject pulse", int'(err_o), 1);
    check(busy_o == 1'b0, "R1", "stays idle on reject", int'(busy_o), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(ent_valid_o == 1'b0 && err_o == 1'b0, "R1", "no entry after reject", int'(ent_valid_o), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ent_valid_o == 1'b0, "R6", "reset valid", int'(ent_valid_o), 0);
    check(busy_o == 1'b0 && done_o == 1'b0 && err_o == 1'b0, "R9", "reset flags", int'(busy_o), 0);

    reject_case(0, 5);
    reject_case(32, 3);
    reject_case(63, 1);
    reject_case(4, 0);

    run_case(1, 1, 100, 0);
    run_case(2, 1, 100, 0);
    run_case(31, 1, 60, 0);
    run_case(3, 2, 100, 0);
    run_case(31, 30, 50, 0);
    run_case(1, 2, 100, 0);
    run_case(1, 255, 40, 0);
    run_case(30, 31, 70, 0);
    run_case(31, 255, 100, 0);
    run_case(5, 3, 30, 1);
    run_case(4, 9, 50, 1);

    for (int t = 0; t < 30; t++) begin
      int n = 1 + int'($urandom % 31);
      int d = 1 + int'($urandom % 255);
      int g = gcd(n, d);
      run_case(n / g, d / g, 20 + int'($urandom % 81), ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule